// File: doc/BRIEF.md
# Flash Partition Dual-Work Arbiter

This block sits in front of a multi-plane flash array whose four planes can be grouped into partitions at run time. A 3-bit grouping code decides where the partition boundaries fall. For every incoming request the block maps the target plane to a partition index. It then decides whether the request may start, given what the other partitions are doing. It keeps a per-partition operating mode, so status is reported for each partition and not for the shared write engine.

Only one write engine exists. At most one program or erase can therefore be in flight, and requests are never queued. A write-class request that arrives while the engine is owned is turned away with a one-cycle reject pulse. Reads in partitions that are not busy stay allowed. A full-array erase claims every partition of the current grouping. The grouping itself can only be rewritten while the whole array is idle.

Top module: `flash_dw_arbiter`

## Requirements
- R1: After a synchronous active-low reset, all partitions are idle, no pulse is raised, and the grouping code equals the parameter-selected default: 3'b100 (planes 0-2 | plane 3) when `TOP_PARAM_BLOCKS` is 1, and 3'b001 (plane 0 | planes 1-3) when it is 0.
- R2: Code bit k (k = 0..2) places a partition boundary between plane k and plane k+1. `req_part` is combinational and equals the number of set code bits below `req_plane`. Code 000 therefore gives one partition, and code 111 gives four single-plane partitions.
- R3: A grouping write (`cfg_wr` with `cfg_code`) made while every partition is idle and `req_valid` is low is accepted. The new mapping is in effect from the next cycle.
- R4: A grouping write made while any partition is busy is rejected, and the mapping stays unchanged.
- R5: A read (op 0) is accepted exactly when the partition it maps to is not busy.
- R6: Program (op 1), block erase (op 2) and one-time-area program (op 4) are accepted when no partition is busy. Each marks only the target partition busy, and never more than one partition holds such a mode.
- R7: Any write-class request (ops 1-4) made while any partition is busy is rejected and changes no partition state. This includes a request made in the same cycle as `eng_done`.
- R8: A full-array erase (op 3) is accepted when all partitions are idle. It marks every partition present in the current grouping as busy, so reads everywhere are rejected until it finishes.
- R9: `eng_done` returns every partition to idle at the next clock edge. When all partitions are already idle it has no effect, and a write accepted in that same cycle still takes effect.
- R10: Every request or grouping write produces exactly one of `req_accept` or `req_reject`, one cycle after it is presented. Neither pulse rises without a request.
- R11: `cfg_wr` and `req_valid` in the same cycle are both refused. This gives a single reject pulse, and neither the mapping nor any mode changes.
- R12: A `part_busy` bit whose partition index is at or above the current partition count is always 0.
- R13: Op codes 5, 6 and 7 are reserved and are always rejected without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_plane | input | 2 | Plane index of the target address |
| req_op | input | 3 | Operation class: 0 read, 1 program, 2 block erase, 3 full-array erase, 4 one-time-area program |
| cfg_wr | input | 1 | Grouping-code write strobe |
| cfg_code | input | 3 | New grouping code |
| eng_done | input | 1 | Completion pulse from the shared write engine |
| req_part | output | 2 | Partition index of `req_plane` under the current code |
| req_accept | output | 1 | One-cycle accept pulse |
| req_reject | output | 1 | One-cycle reject pulse |
| part_busy | output | 4 | Per-partition busy flags, indexed by partition |

## Verification
The assertions take for granted that `eng_done` arrives only for an operation this block admitted. They also assume the inputs hold known values from the first clock, since several properties compare against the previous cycle's busy vector and done strobe. The stimulus respects both assumptions. It drives every input to zero from time zero, presents each request for exactly one cycle, and raises `eng_done` only after a write has been accepted, apart from the deliberate done-while-idle cases. The sweep covers every grouping code, every target plane and every write class, and probes reads, writes and regrouping in each plane while a write is outstanding.

// File: rtl/flash_dw_pkg.sv
// Package: shared constants and types for the partition dual-work arbiter.
// Assumes four planes by default; op classes are 3-bit codes.
package flash_dw_pkg;

    localparam int DW_PLANES = 4;

    localparam logic [2:0] OPC_READ   = 3'd0;
    localparam logic [2:0] OPC_PROG   = 3'd1;
    localparam logic [2:0] OPC_BERASE = 3'd2;
    localparam logic [2:0] OPC_CERASE = 3'd3;
    localparam logic [2:0] OPC_OTP    = 3'd4;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_PROG   = 3'd1,
        MODE_BERASE = 3'd2,
        MODE_CERASE = 3'd3,
        MODE_OTP    = 3'd4
    } part_mode_e;

endpackage

// File: rtl/dw_plane_map.sv
// Module: dw_plane_map
// Maps a plane index to a partition index: bit k of the code is a boundary
// between plane k and plane k+1, so the index is the count of boundaries below.
// Also reports which partition indices exist under the code.
// Assumes N_PLANES >= 2.
module dw_plane_map #(
    parameter  int N_PLANES = flash_dw_pkg::DW_PLANES,
    localparam int PW       = $clog2(N_PLANES),
    localparam int CW       = N_PLANES - 1
) (
    input  logic [CW-1:0]       code,
    input  logic [PW-1:0]       plane,
    output logic [PW-1:0]       part,
    output logic [N_PLANES-1:0] part_present
);

    logic [PW-1:0] idx [N_PLANES];

    // Prefix count of boundaries: plane 0 always lands in partition 0.
    assign idx[0] = '0;

    generate
        for (genvar p = 1; p < N_PLANES; p++) begin : g_prefix
            assign idx[p] = idx[p-1] + PW'(code[p-1]);
        end
        for (genvar i = 0; i < N_PLANES; i++) begin : g_present
            // A partition exists when its index does not exceed the last plane's index.
            assign part_present[i] = (PW'(i) <= idx[N_PLANES-1]);
        end
    endgenerate

    // Select the index belonging to the requested plane.
    assign part = idx[plane];

endmodule

// File: rtl/dw_cfg_reg.sv
// Module: dw_cfg_reg
// Holds the grouping code. Resets to the default implied by where the
// parameter blocks sit; loads only when the admission logic says so.
module dw_cfg_reg #(
    parameter  int N_PLANES         = flash_dw_pkg::DW_PLANES,
    parameter  bit TOP_PARAM_BLOCKS = 1'b1,
    localparam int CW               = N_PLANES - 1,
    localparam logic [CW-1:0] CODE_RST =
        TOP_PARAM_BLOCKS ? CW'(1) << (CW - 1) : CW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] new_code,
    output logic [CW-1:0] code
);

    // Code register: default on reset, new value on an admitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)    code <= CODE_RST;
        else if (load) code <= new_code;
    end

endmodule

// File: rtl/dw_part_modes.sv
// Module: dw_part_modes
// Per-partition mode registers. A set writes one partition (or all present
// ones for a full-array erase); a clear from the engine returns all to idle.
// Assumes sets are only issued when every partition is idle.
module dw_part_modes
    import flash_dw_pkg::*;
#(
    parameter  int N_PLANES = DW_PLANES,
    localparam int PW       = $clog2(N_PLANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                set_all,
    input  logic [PW-1:0]       set_part,
    input  part_mode_e          set_mode,
    input  logic [N_PLANES-1:0] present,
    input  logic                clr,
    output logic [N_PLANES-1:0] busy
);

    part_mode_e          mode [N_PLANES];
    logic [N_PLANES-1:0] single_owner;
    logic [N_PLANES-1:0] chip_erasing;

    generate
        for (genvar i = 0; i < N_PLANES; i++) begin : g_part
            logic hit;
            // Does this partition receive the new mode?
            assign hit = set_all ? present[i] : (set_part == PW'(i));

            // Mode register: a set wins over a clear (sets only happen when idle).
            always_ff @(posedge clk) begin
                if (!rst_n)              mode[i] <= MODE_IDLE;
                else if (set_en && hit)  mode[i] <= set_mode;
                else if (clr)            mode[i] <= MODE_IDLE;
            end

            assign busy[i]         = (mode[i] != MODE_IDLE);
            assign single_owner[i] = (mode[i] == MODE_PROG) || (mode[i] == MODE_BERASE)
                                   || (mode[i] == MODE_OTP);
            assign chip_erasing[i] = (mode[i] == MODE_CERASE);
        end
    endgenerate

    // At most one partition owns the engine for a single-partition write.
    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(single_owner));

    // A full-array erase covers exactly the partitions that exist.
    assert_chip_erase_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|chip_erasing) |-> (chip_erasing == present));

    // Non-existent partitions never report busy.
    assert_unused_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & ~present) == '0);

    // An engine completion while busy leaves everything idle.
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (|busy)) |=> (busy == '0));

endmodule

// File: rtl/dw_admit.sv
// Module: dw_admit
// Decides whether a request or grouping write may start, drives the mode-set
// and code-load controls, and registers the accept/reject pulses.
// Assumes requests and grouping writes last one cycle each.
module dw_admit
    import flash_dw_pkg::*;
#(
    parameter  int N_PLANES = DW_PLANES,
    localparam int PW       = $clog2(N_PLANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [PW-1:0]       tgt_part,
    input  logic                cfg_wr,
    input  logic [N_PLANES-1:0] busy,
    output logic                cfg_load,
    output logic                set_en,
    output logic                set_all,
    output part_mode_e          set_mode,
    output logic                accept,
    output logic                reject
);

    logic any_busy;
    logic tgt_busy;
    logic ok;
    logic event_in;

    assign any_busy = |busy;
    assign tgt_busy = busy[tgt_part];
    assign event_in = req_valid || cfg_wr;

    // Admission decision and resulting control strobes.
    always_comb begin
        ok       = 1'b0;
        cfg_load = 1'b0;
        set_en   = 1'b0;
        set_all  = 1'b0;
        set_mode = MODE_IDLE;
        if (req_valid && cfg_wr) begin
            ok = 1'b0;
        end else if (cfg_wr) begin
            ok       = !any_busy;
            cfg_load = ok;
        end else if (req_valid) begin
            case (req_op)
                OPC_READ:   ok = !tgt_busy;
                OPC_PROG: begin
                    ok = !any_busy; set_en = ok; set_mode = MODE_PROG;
                end
                OPC_BERASE: begin
                    ok = !any_busy; set_en = ok; set_mode = MODE_BERASE;
                end
                OPC_OTP: begin
                    ok = !any_busy; set_en = ok; set_mode = MODE_OTP;
                end
                OPC_CERASE: begin
                    ok = !any_busy; set_en = ok; set_all = 1'b1; set_mode = MODE_CERASE;
                end
                default:    ok = 1'b0;
            endcase
        end
    end

    // Registered one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            reject <= 1'b0;
        end else begin
            accept <= event_in && ok;
            reject <= event_in && !ok;
        end
    end

    // Outcome pulses are mutually exclusive.
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    // A pulse only follows a presented request.
    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> $past(event_in));

endmodule

// File: rtl/flash_dw_arbiter.sv
// Module: flash_dw_arbiter (top)
// Maps planes to run-time partitions and admits reads, programs and erases
// against a single shared write engine. Assumes eng_done only follows an
// admitted write.
module flash_dw_arbiter
    import flash_dw_pkg::*;
#(
    parameter  int N_PLANES         = DW_PLANES,
    parameter  bit TOP_PARAM_BLOCKS = 1'b1,
    localparam int PW               = $clog2(N_PLANES),
    localparam int CW               = N_PLANES - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [PW-1:0]       req_plane,
    input  logic [2:0]          req_op,
    input  logic                cfg_wr,
    input  logic [CW-1:0]       cfg_code,
    input  logic                eng_done,
    output logic [PW-1:0]       req_part,
    output logic                req_accept,
    output logic                req_reject,
    output logic [N_PLANES-1:0] part_busy
);

    logic [CW-1:0]       code;
    logic [N_PLANES-1:0] present;
    logic                cfg_load;
    logic                set_en;
    logic                set_all;
    part_mode_e          set_mode;

    dw_cfg_reg #(.N_PLANES(N_PLANES), .TOP_PARAM_BLOCKS(TOP_PARAM_BLOCKS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .new_code(cfg_code), .code(code)
    );

    dw_plane_map #(.N_PLANES(N_PLANES)) u_map (
        .code(code), .plane(req_plane), .part(req_part), .part_present(present)
    );

    dw_admit #(.N_PLANES(N_PLANES)) u_admit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .tgt_part(req_part), .cfg_wr(cfg_wr), .busy(part_busy),
        .cfg_load(cfg_load), .set_en(set_en), .set_all(set_all), .set_mode(set_mode),
        .accept(req_accept), .reject(req_reject)
    );

    dw_part_modes #(.N_PLANES(N_PLANES)) u_modes (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_all(set_all),
        .set_part(req_part), .set_mode(set_mode), .present(present),
        .clr(eng_done), .busy(part_busy)
    );

    // The grouping only changes across an edge where nothing was busy.
    assert_cfg_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> ($past(part_busy) == '0));

    // A rejected request leaves the busy state untouched (absent a completion).
    assert_reject_nochange_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_reject && !$past(eng_done)) |-> $stable(part_busy));

endmodule

// File: tb/tb_flash_dw_arbiter.sv
`timescale 1ns/1ps
module tb_flash_dw_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_plane = 2'd0;
    logic [2:0] req_op = 3'd0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_code = 3'd0;
    logic       eng_done = 1'b0;
    logic [1:0] req_part;
    logic       req_accept;
    logic       req_reject;
    logic [3:0] part_busy;
    logic [1:0] b_part;
    logic       b_acc, b_rej;
    logic [3:0] b_busy;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    flash_dw_arbiter #(.TOP_PARAM_BLOCKS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_plane(req_plane),
        .req_op(req_op), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .eng_done(eng_done),
        .req_part(req_part), .req_accept(req_accept), .req_reject(req_reject),
        .part_busy(part_busy)
    );

    flash_dw_arbiter #(.TOP_PARAM_BLOCKS(1'b0)) dut_bot (
        .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_plane(req_plane),
        .req_op(3'd0), .cfg_wr(1'b0), .cfg_code(3'd0), .eng_done(1'b0),
        .req_part(b_part), .req_accept(b_acc), .req_reject(b_rej), .part_busy(b_busy)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Partition index from the boundary rule: count set code bits below the plane.
    function automatic int part_of(input int code, input int plane);
        int n = 0;
        for (int j = 0; j < plane; j++) if (((code >> j) & 1) == 1) n++;
        return n;
    endfunction

    // One-cycle stimulus; returns after the edge with pulses visible.
    task automatic step(input logic v, input logic [2:0] op, input logic [1:0] pl,
                        input logic cw, input logic [2:0] cc, input logic dn);
        @(negedge clk);
        req_valid = v; req_op = op; req_plane = pl;
        cfg_wr = cw; cfg_code = cc; eng_done = dn;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b0; eng_done = 1'b0;
    endtask

    task automatic chk_map(input string rq, input int code);
        for (int pl = 0; pl < 4; pl++) begin
            req_plane = 2'(pl);
            #1;
            chk(rq, int'(req_part), part_of(code, pl));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int exp_mask;
        int np;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state for both parameter settings
        chk("R1 busy", int'(part_busy), 0);
        chk("R1 accept", int'(req_accept), 0);
        chk("R1 reject", int'(req_reject), 0);
        chk_map("R1 top default", 3'b100);
        for (int pl = 0; pl < 4; pl++) begin
            req_plane = 2'(pl); #1;
            chk("R1 bottom default", int'(b_part), part_of(3'b001, pl));
        end

        for (int code = 0; code < 8; code++) begin
            np = part_of(code, 3) + 1;
            step(1'b0, 3'd0, 2'd0, 1'b1, 3'(code), 1'b0);
            chk("R3 cfg accept", int'(req_accept), 1);
            chk_map("R2 mapping", code);
            for (int wop = 1; wop <= 4; wop++) begin
                for (int tp = 0; tp < 4; tp++) begin
                    step(1'b1, 3'(wop), 2'(tp), 1'b0, 3'd0, 1'b0);
                    chk("R6 write accept", int'(req_accept), 1);
                    // R8 full-array erase claims all present partitions; R12 others stay 0
                    exp_mask = (wop == 3) ? ((1 << np) - 1) : (1 << part_of(code, tp));
                    chk(wop == 3 ? "R8 busy mask" : "R6 busy mask", int'(part_busy), exp_mask);
                    for (int q = 0; q < 4; q++) begin
                        step(1'b1, 3'd0, 2'(q), 1'b0, 3'd0, 1'b0);
                        chk("R5 read outcome", int'(req_accept),
                            ((exp_mask >> part_of(code, q)) & 1) == 1 ? 0 : 1);
                        step(1'b1, 3'd1, 2'(q), 1'b0, 3'd0, 1'b0);
                        chk("R7 write reject", int'(req_reject), 1);
                        chk("R7 busy kept", int'(part_busy), exp_mask);
                    end
                    step(1'b0, 3'd0, 2'd0, 1'b1, 3'(code ^ 7), 1'b0);
                    chk("R4 cfg reject", int'(req_reject), 1);
                    req_plane = 2'd3; #1;
                    chk("R4 mapping kept", int'(req_part), part_of(code, 3));
                    step(1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 1'b1);
                    chk("R9 done clears", int'(part_busy), 0);
                    chk("R10 no pulse", int'(req_accept) + int'(req_reject), 0);
                end
            end
        end

        // R13: reserved op codes
        for (int op = 5; op < 8; op++) begin
            step(1'b1, 3'(op), 2'd1, 1'b0, 3'd0, 1'b0);
            chk("R13 reserved reject", int'(req_reject), 1);
            chk("R13 busy", int'(part_busy), 0);
        end

        // R11: simultaneous grouping write and request (current code is 111)
        step(1'b1, 3'd1, 2'd0, 1'b1, 3'b000, 1'b0);
        chk("R11 reject", int'(req_reject), 1);
        chk("R11 accept", int'(req_accept), 0);
        chk("R11 busy", int'(part_busy), 0);
        req_plane = 2'd3; #1;
        chk("R11 mapping kept", int'(req_part), 3);

        // R9: completion while idle has no effect; write in same cycle takes effect
        step(1'b0, 3'd0, 2'd0, 1'b0, 3'd0, 1'b1);
        chk("R9 idle done", int'(part_busy), 0);
        step(1'b1, 3'd1, 2'd2, 1'b0, 3'd0, 1'b1);
        chk("R9 write with idle done", int'(part_busy), 4'b0100);

        // R7: write in the same cycle as the completion is still rejected
        step(1'b1, 3'd2, 2'd1, 1'b0, 3'd0, 1'b1);
        chk("R7 reject at done", int'(req_reject), 1);
        chk("R7 idle after done", int'(part_busy), 0);

        // R10: quiet cycle produces no pulse
        @(negedge clk);
        chk("R10 quiet", int'(req_accept) + int'(req_reject), 0);

        finish_run();
    end

endmodule